// File: doc/BRIEF.md
# Vertical-First Element Step Unit

This block keeps the 64-bit vector loop-state word of a core running in vertical-first mode and executes the step-and-status operation on it. In vertical-first mode, every vector instruction works on one element only. Software then advances the loop position explicitly with this operation. It moves the source and destination element counters and their sub-element counters to the next element. Each step honours the pack and unpack loop-order flags and, with non-zeroing predication, the predicate mask. The same operation can also report the counters, or set or clear the pack and unpack flags.

An operation is presented for one cycle with `op_valid`, together with:
- a 7-bit mode code;
- a step-enable bit;
- a condition-record bit;
- the sub-vector length code;
- a 64-bit predicate mask and a zeroing flag.

One cycle later `done` pulses, and `res_data`, `res_cr` and `state_q` carry the outcome. The whole state word can be written with `st_load`. This is how a context is restored or how the vector and maximum lengths are established. Remapped index schedules are not computed: their enquiry codes return zero.

Top module: `vfs_step_unit`

## Requirements
- R1: After reset, `state_q`, `res_data` and `res_cr` are zero and `done` is low.
- R2: The state word is laid out in the following fields:

  | Field | Bits | Field | Bits |
  |---|---|---|---|
  | maximum length | [63:57] | pack flag | [10] |
  | vector length (vl) | [56:50] | unpack flag | [9] |
  | source element | [49:43] | group hint | [8:2] |
  | destination element | [42:36] | persist | [1] |
  | destination sub-element | [35:34] | vertical-first | [0] |
  | source sub-element | [33:32] | | |

  A cycle with `st_load` high writes `st_wdata` into the state word at the clock edge. `st_load` takes precedence over `op_valid`, and an operation is then dropped without a `done` pulse.
- R3: `done` is high exactly in the cycle after an accepted `op_valid` and low otherwise. `res_data` and `res_cr` are updated in that same cycle.
- R4: When `op_mode[3:2]` is binary 11, the pack flag takes `op_mode[0]` and the unpack flag takes `op_mode[1]`, whatever the value of `op_vf`. The result is pack in bit 1 and unpack in bit 0, with all other bits zero.
- R5: Mode code 5 returns the source element and mode 6 returns the destination element, both zero-extended. Codes 1 to 4, and every other code whose bits [3:2] are not 11, return zero.
- R6: For any code whose bits [3:2] are not 11, `op_vf=0` leaves the state word unchanged. Mode 0 with `op_vf=0` returns the current source element.
- R7: Mode 0 with `op_vf=1` advances each side (source and destination) and returns the new source element. With the side's flag clear, the sub-element counter advances first and the element moves on when the sub-element wraps past `subvl_code`. With the flag set, the element moves first and the sub-element advances when the element wraps.
- R8: With `pred_zero` low, an element counter moves only to elements below vl whose mask bit is set, skipping any masked-out ones. With `pred_zero` high, every element below vl is visited.
- R9: When a side advances past its last eligible element, its element counter returns to the first eligible element (0 if none). When both the sub-element and the element wrap, this is the loop end.
- R10: With `op_rc=1`, `res_cr` is {LT, GT, EQ, SO} in bits [3:0]:
  - GT means the result is non-zero.
  - EQ means the result is zero.
  - SO is the source-side loop end of a step.
  - LT is the group-end flag described in R11.

  With `op_rc=0`, `res_cr` is zero.
- R11: LT is set on a step when all of the following hold: vertical-first is set, the group hint h is non-zero, and floor(source/h) differs before and after the step.
- R12: An operation never changes the maximum length, vl, group hint, persist or vertical-first fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_load | input | 1 | Write the whole state word |
| st_wdata | input | 64 | State word to write |
| op_valid | input | 1 | Operation strobe |
| op_mode | input | 7 | Mode code |
| op_vf | input | 1 | Step enable |
| op_rc | input | 1 | Produce the condition field |
| subvl_code | input | 2 | Sub-vector length minus one |
| pred_mask | input | 64 | Predicate mask, bit i for element i |
| pred_zero | input | 1 | Zeroing predication (no skipping) |
| res_data | output | 64 | Operation result |
| res_cr | output | 4 | Condition field {LT,GT,EQ,SO} |
| state_q | output | 64 | Current state word |
| done | output | 1 | Operation completed pulse |

## Verification
On every cycle, the assertions check the following:
- the `done` pulse timing;
- that report-only operations leave the state word alone;
- that the length, hint and mode fields survive any operation;
- the pack and unpack writes;
- source-element reporting;
- that a step always leaves the source element below vl.

Some behaviour can only be shown by the bench's reference model: the exact landing element after predicate skipping, the two loop orders, the wrap point with its SO flag, and the group-end LT flag. The bench drives both directed sequences and random states, masks and modes for these.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  localparam int DATA_W = 64;
  localparam int ELEM_W = 7;
  localparam int SUB_W  = 2;
  localparam int CR_W   = 4;

  // state word field positions (LSB of each field)
  localparam int MAXVL_LSB = 57;
  localparam int VL_LSB    = 50;
  localparam int SRC_LSB   = 43;
  localparam int DST_LSB   = 36;
  localparam int DSUB_LSB  = 34;
  localparam int SSUB_LSB  = 32;
  localparam int PACK_BIT  = 10;
  localparam int UNPK_BIT  = 9;
  localparam int HINT_LSB  = 2;
  localparam int PERS_BIT  = 1;
  localparam int VFST_BIT  = 0;

  // condition field bit positions
  localparam int CR_LT = 3;
  localparam int CR_GT = 2;
  localparam int CR_EQ = 1;
  localparam int CR_SO = 0;

  typedef enum logic [1:0] {
    OPK_STEP   = 2'd0,
    OPK_FLAGS  = 2'd1,
    OPK_REPORT = 2'd2
  } op_kind_e;
endpackage

// File: rtl/vfs_elem_find.sv
module vfs_elem_find #(
  parameter int MASK_W = 64,
  parameter int ELEM_W = 7
) (
  input  logic [ELEM_W-1:0] cur,
  input  logic [ELEM_W-1:0] vl,
  input  logic [MASK_W-1:0] mask,
  input  logic              zero,
  output logic [ELEM_W-1:0] nxt,
  output logic              nxt_ok,
  output logic [ELEM_W-1:0] first
);
  logic [MASK_W-1:0] elig;

  for (genvar g = 0; g < MASK_W; g++) begin : g_elig
    assign elig[g] = (ELEM_W'(g) < vl) && (zero || mask[g]);
  end

  // priority search: lowest eligible index overall and above cur
  always_comb begin
    nxt    = '0;
    nxt_ok = 1'b0;
    first  = '0;
    for (int e = MASK_W - 1; e >= 0; e--) begin
      if (elig[e]) begin
        first = ELEM_W'(e);
        if (ELEM_W'(e) > cur) begin
          nxt    = ELEM_W'(e);
          nxt_ok = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vfs_side_adv.sv
module vfs_side_adv #(
  parameter int MASK_W = 64,
  parameter int ELEM_W = 7,
  parameter int SUB_W  = 2
) (
  input  logic [ELEM_W-1:0] elem,
  input  logic [SUB_W-1:0]  sub,
  input  logic              elem_inner,
  input  logic [ELEM_W-1:0] vl,
  input  logic [SUB_W-1:0]  sub_last,
  input  logic [MASK_W-1:0] mask,
  input  logic              zero,
  output logic [ELEM_W-1:0] n_elem,
  output logic [SUB_W-1:0]  n_sub,
  output logic              wrap
);
  logic [ELEM_W-1:0] f_nxt, f_first;
  logic              f_ok, sub_end;

  vfs_elem_find #(.MASK_W(MASK_W), .ELEM_W(ELEM_W)) u_find (
    .cur(elem), .vl(vl), .mask(mask), .zero(zero),
    .nxt(f_nxt), .nxt_ok(f_ok), .first(f_first)
  );

  assign sub_end = (sub >= sub_last);

  always_comb begin
    n_elem = elem;
    n_sub  = sub;
    wrap   = 1'b0;
    if (!elem_inner) begin
      if (!sub_end) begin
        n_sub = sub + SUB_W'(1);
      end else begin
        n_sub  = '0;
        n_elem = f_ok ? f_nxt : f_first;
        wrap   = !f_ok;
      end
    end else begin
      if (f_ok) begin
        n_elem = f_nxt;
      end else begin
        n_elem = f_first;
        n_sub  = sub_end ? '0 : sub + SUB_W'(1);
        wrap   = sub_end;
      end
    end
  end
endmodule

// File: rtl/vfs_step_unit.sv
module vfs_step_unit
  import vfs_pkg::*;
#(
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_load,
  input  logic [DATA_W-1:0] st_wdata,
  input  logic              op_valid,
  input  logic [6:0]        op_mode,
  input  logic              op_vf,
  input  logic              op_rc,
  input  logic [SUB_W-1:0]  subvl_code,
  input  logic [MASK_W-1:0] pred_mask,
  input  logic              pred_zero,
  output logic [DATA_W-1:0] res_data,
  output logic [CR_W-1:0]   res_cr,
  output logic [DATA_W-1:0] state_q,
  output logic              done
);
  localparam int SIDES = 2;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  // field views
  logic [ELEM_W-1:0] vl, src, dst, hint;
  logic [SUB_W-1:0]  ssub, dsub;
  logic              pack_f, unpk_f, vfirst;
  assign vl     = state_q[VL_LSB   +: ELEM_W];
  assign src    = state_q[SRC_LSB  +: ELEM_W];
  assign dst    = state_q[DST_LSB  +: ELEM_W];
  assign hint   = state_q[HINT_LSB +: ELEM_W];
  assign ssub   = state_q[SSUB_LSB +: SUB_W];
  assign dsub   = state_q[DSUB_LSB +: SUB_W];
  assign pack_f = state_q[PACK_BIT];
  assign unpk_f = state_q[UNPK_BIT];
  assign vfirst = state_q[VFST_BIT];

  // side 0 = source, side 1 = destination
  logic [ELEM_W-1:0] sd_elem  [SIDES];
  logic [SUB_W-1:0]  sd_sub   [SIDES];
  logic              sd_inner [SIDES];
  logic [ELEM_W-1:0] sd_nelem [SIDES];
  logic [SUB_W-1:0]  sd_nsub  [SIDES];
  logic              sd_wrap  [SIDES];

  assign sd_elem[0]  = src;
  assign sd_sub[0]   = ssub;
  assign sd_inner[0] = pack_f;
  assign sd_elem[1]  = dst;
  assign sd_sub[1]   = dsub;
  assign sd_inner[1] = unpk_f;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    vfs_side_adv #(.MASK_W(MASK_W), .ELEM_W(ELEM_W), .SUB_W(SUB_W)) u_adv (
      .elem(sd_elem[s]), .sub(sd_sub[s]), .elem_inner(sd_inner[s]),
      .vl(vl), .sub_last(subvl_code), .mask(pred_mask), .zero(pred_zero),
      .n_elem(sd_nelem[s]), .n_sub(sd_nsub[s]), .wrap(sd_wrap[s])
    );
  end

  // group boundary detection for the hint
  logic [ELEM_W-1:0] hint_div;
  logic              grp_end;
  assign hint_div = (hint == '0) ? ELEM_W'(1) : hint;
  assign grp_end  = vfirst && (hint != '0) &&
                    ((src / hint_div) != (sd_nelem[0] / hint_div));

  // operation classification
  op_kind_e kind;
  always_comb begin
    if (op_mode[3:2] == 2'b11)  kind = OPK_FLAGS;
    else if (op_mode == 7'd0)   kind = OPK_STEP;
    else                        kind = OPK_REPORT;
  end

  // next state
  logic [DATA_W-1:0] state_d, res_d;
  logic [CR_W-1:0]   cr_d;
  logic [ELEM_W-1:0] val;
  logic              lt_d, so_d, done_d, st_en, res_en;

  always_comb begin
    state_d = state_q;
    val     = '0;
    lt_d    = 1'b0;
    so_d    = 1'b0;
    res_d   = '0;
    case (kind)
      OPK_FLAGS: begin
        state_d[PACK_BIT] = op_mode[0];
        state_d[UNPK_BIT] = op_mode[1];
        val = {{(ELEM_W-2){1'b0}}, op_mode[0], op_mode[1]};
      end
      OPK_STEP: begin
        if (op_vf) begin
          state_d[SRC_LSB  +: ELEM_W] = sd_nelem[0];
          state_d[SSUB_LSB +: SUB_W]  = sd_nsub[0];
          state_d[DST_LSB  +: ELEM_W] = sd_nelem[1];
          state_d[DSUB_LSB +: SUB_W]  = sd_nsub[1];
          val  = sd_nelem[0];
          lt_d = grp_end;
          so_d = sd_wrap[0];
        end else begin
          val = src;
        end
      end
      default: begin
        if (op_mode == 7'd5)      val = src;
        else if (op_mode == 7'd6) val = dst;
        else                      val = '0;
      end
    endcase
    res_d = {{(DATA_W-ELEM_W){1'b0}}, val};
    cr_d  = '0;
    if (op_rc) begin
      cr_d[CR_LT] = lt_d;
      cr_d[CR_GT] = (val != '0);
      cr_d[CR_EQ] = (val == '0);
      cr_d[CR_SO] = so_d;
    end
    if (st_load) state_d = st_wdata;
    done_d = op_valid && !st_load;
    res_en = done_d;
    st_en  = st_load || done_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      state_q  <= '0;
      res_data <= '0;
      res_cr   <= '0;
      done     <= 1'b0;
    end else begin
      done <= done_d;
      if (st_en)  state_q <= state_d;
      if (res_en) begin
        res_data <= res_d;
        res_cr   <= cr_d;
      end
    end
  end
endmodule

// File: rtl/vfs_step_chk.sv
module vfs_step_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        st_load,
  input logic        op_valid,
  input logic [6:0]  op_mode,
  input logic        op_vf,
  input logic        op_rc,
  input logic [63:0] state_q,
  input logic [63:0] res_data,
  input logic [3:0]  res_cr,
  input logic        done
);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && !st_load) |=> done);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!op_valid || st_load) |=> !done);
  // R6
  report_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && !st_load && !op_vf && op_mode[3:2] != 2'b11) |=> state_q == $past(state_q));
  // R10
  cr_off_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && !st_load && !op_rc) |=> res_cr == 4'b0);
  // R4
  pack_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && !st_load && op_mode[3:2] == 2'b11) |=>
      (state_q[10] == $past(op_mode[0]) && state_q[9] == $past(op_mode[1])));
  // R12
  fixed_fields_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && !st_load) |=>
      (state_q[63:50] == $past(state_q[63:50]) && state_q[8:0] == $past(state_q[8:0])));
  // R5
  src_report_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && !st_load && op_mode == 7'd5) |=> res_data == {57'b0, $past(state_q[49:43])});
  // R9
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && !st_load && op_mode == 7'd0 && op_vf &&
     state_q[56:50] != 7'd0 && state_q[56:50] <= 7'd64) |=> state_q[49:43] < state_q[56:50]);
endmodule

bind vfs_step_unit vfs_step_chk u_chk (.*);

// File: tb/sim_vfs_step_unit.sv
module sim_vfs_step_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_load, op_valid, op_vf, op_rc, pred_zero;
  logic [63:0] st_wdata, pred_mask;
  logic [6:0]  op_mode;
  logic [1:0]  subvl_code;
  logic [63:0] res_data, state_q;
  logic [3:0]  res_cr;
  logic        done;

  int total = 0;
  int bad   = 0;
  logic [63:0] exp_st;

  always #5 clk = ~clk;

  vfs_step_unit u0 (.*);

  task automatic chk64(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // returns {wrap, elem[6:0], sub[1:0]}
  function automatic logic [9:0] side_step(input logic [6:0] e, input logic [1:0] s, input logic einner,
                                           input logic [6:0] vl, input logic [1:0] last,
                                           input logic [63:0] m, input logic z);
    int nx = -1;
    int fst = -1;
    for (int i = 0; i < 64; i++) begin
      if (i < int'(vl) && (z || m[i])) begin
        if (fst < 0) fst = i;
        if (nx < 0 && i > int'(e)) nx = i;
      end
    end
    if (fst < 0) fst = 0;
    if (!einner) begin
      if (s < last)    return {1'b0, e, s + 2'd1};
      else if (nx >= 0) return {1'b0, 7'(nx), 2'd0};
      else             return {1'b1, 7'(fst), 2'd0};
    end else begin
      if (nx >= 0)     return {1'b0, 7'(nx), s};
      else if (s < last) return {1'b0, 7'(fst), s + 2'd1};
      else             return {1'b1, 7'(fst), 2'd0};
    end
  endfunction

  task automatic do_load(input logic [63:0] w);
    @(negedge clk);
    st_load = 1'b1; st_wdata = w;
    @(negedge clk);
    st_load = 1'b0;
    exp_st = w;
    chk64("R2", "state after load", state_q, w);
  endtask

  task automatic do_op(input string tag, input logic [6:0] md, input logic vf, input logic rc,
                       input logic [1:0] sv, input logic [63:0] m, input logic z);
    logic [63:0] nst, er;
    logic [6:0]  v, src, dst, hint;
    logic [9:0]  a, b;
    logic        lt, so;
    logic [3:0]  ecr;
    nst = exp_st; v = 7'd0; lt = 1'b0; so = 1'b0;
    src = exp_st[49:43]; dst = exp_st[42:36]; hint = exp_st[8:2];
    if (md[3:2] == 2'b11) begin
      nst[10] = md[0]; nst[9] = md[1];
      v = {5'd0, md[0], md[1]};
    end else if (md == 7'd0) begin
      if (vf) begin
        a = side_step(src, exp_st[33:32], exp_st[10], exp_st[56:50], sv, m, z);
        b = side_step(dst, exp_st[35:34], exp_st[9],  exp_st[56:50], sv, m, z);
        nst[49:43] = a[8:2]; nst[33:32] = a[1:0];
        nst[42:36] = b[8:2]; nst[35:34] = b[1:0];
        v = a[8:2]; so = a[9];
        lt = exp_st[0] && hint != 0 && ((src / hint) != (a[8:2] / hint));
      end else v = src;
    end else if (md == 7'd5) v = src;
    else if (md == 7'd6) v = dst;
    er  = {57'd0, v};
    ecr = rc ? {lt, v != 0, v == 0, so} : 4'd0;
    @(negedge clk);
    op_valid = 1'b1; op_mode = md; op_vf = vf; op_rc = rc;
    subvl_code = sv; pred_mask = m; pred_zero = z;
    @(negedge clk);
    op_valid = 1'b0;
    chk64(tag, "done", {63'd0, done}, 64'd1);
    chk64(tag, "result", res_data, er);
    chk64(tag, "cr", {60'd0, res_cr}, {60'd0, ecr});
    chk64(tag, "state", state_q, nst);
    exp_st = nst;
  endtask

  function automatic logic [63:0] mk_state(input logic [6:0] vl, input logic [6:0] s, input logic [6:0] d,
                                           input logic [1:0] ss, input logic [1:0] ds, input logic pk,
                                           input logic up, input logic [6:0] h, input logic vfst);
    logic [63:0] w = 64'd0;
    w[63:57] = 7'd64; w[56:50] = vl; w[49:43] = s; w[42:36] = d;
    w[35:34] = ds; w[33:32] = ss; w[10] = pk; w[9] = up; w[8:2] = h; w[0] = vfst;
    return w;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h00c0ffee));
    rst_n = 1'b0; st_load = 1'b0; st_wdata = '0; op_valid = 1'b0; op_mode = '0;
    op_vf = 1'b0; op_rc = 1'b0; subvl_code = '0; pred_mask = '0; pred_zero = 1'b0;
    exp_st = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk64("R1", "state", state_q, 64'd0);
    chk64("R1", "result", res_data, 64'd0);
    chk64("R1", "cr", {60'd0, res_cr}, 64'd0);
    chk64("R1", "done", {63'd0, done}, 64'd0);

    do_load(mk_state(7'd8, 0, 0, 0, 0, 0, 0, 0, 0));
    // R6: report-only step leaves state
    do_op("R6", 7'd0, 1'b0, 1'b0, 2'd1, '1, 1'b1);
    @(negedge clk);
    // R3: done falls after one cycle
    chk64("R3", "done idle", {63'd0, done}, 64'd0);
    // R7: sub-element first when pack clear
    do_op("R7", 7'd0, 1'b1, 1'b1, 2'd1, '1, 1'b1);
    do_op("R7", 7'd0, 1'b1, 1'b1, 2'd1, '1, 1'b1);
    // R4: pack set, unpack clear
    do_op("R4", 7'd13, 1'b0, 1'b1, 2'd1, '1, 1'b1);
    do_op("R4", 7'd14, 1'b1, 1'b0, 2'd1, '1, 1'b1);
    do_op("R4", 7'd13, 1'b0, 1'b0, 2'd1, '1, 1'b1);
    // R7: element first when pack set
    do_op("R7", 7'd0, 1'b1, 1'b1, 2'd1, '1, 1'b1);
    // R8: skip over masked elements
    do_load(mk_state(7'd8, 0, 0, 0, 0, 0, 0, 0, 0));
    do_op("R8", 7'd0, 1'b1, 1'b1, 2'd0, 64'h91, 1'b0);
    do_op("R8", 7'd0, 1'b1, 1'b1, 2'd0, 64'h91, 1'b0);
    // R9: wrap with SO at loop end
    do_op("R9", 7'd0, 1'b1, 1'b1, 2'd0, 64'h91, 1'b0);
    do_load(mk_state(7'd8, 7, 7, 0, 0, 0, 0, 0, 0));
    do_op("R9", 7'd0, 1'b1, 1'b1, 2'd0, '1, 1'b1);
    // R11: group end with hint 4
    do_load(mk_state(7'd16, 3, 3, 0, 0, 0, 0, 7'd4, 1'b1));
    do_op("R11", 7'd0, 1'b1, 1'b1, 2'd0, '1, 1'b1);
    do_op("R11", 7'd0, 1'b1, 1'b1, 2'd0, '1, 1'b1);
    // R5: reporting codes
    do_load(mk_state(7'd20, 9, 12, 0, 0, 0, 0, 0, 0));
    do_op("R5", 7'd5, 1'b1, 1'b1, 2'd0, '1, 1'b1);
    do_op("R5", 7'd6, 1'b0, 1'b1, 2'd0, '1, 1'b1);
    do_op("R5", 7'd3, 1'b1, 1'b1, 2'd0, '1, 1'b1);
    do_op("R10", 7'd5, 1'b0, 1'b0, 2'd0, '1, 1'b1);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [6:0] md, vl;
      logic [63:0] m;
      int pick;
      if ((n % 40) == 0) begin
        logic [63:0] w;
        vl = 7'(1 + $urandom_range(0, 63));
        w = mk_state(vl, 7'($urandom_range(0, int'(vl) - 1)), 7'($urandom_range(0, int'(vl) - 1)),
                     2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                     7'($urandom_range(0, 7)), 1'($urandom));
        w[1] = 1'($urandom);
        w[31:11] = 21'($urandom);
        do_load(w);
      end
      pick = $urandom_range(0, 9);
      if (pick < 5)      md = 7'd0;
      else if (pick < 7) md = 7'($urandom_range(1, 6));
      else if (pick < 8) md = 7'($urandom_range(12, 15));
      else               md = 7'($urandom);
      m = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) m = 64'd0;
      // R12 fixed fields covered by the state compare in every op
      do_op("R12", md, ($urandom_range(0, 3) != 0), 1'($urandom), 2'($urandom), m, 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule